// File: doc/BRIEF.md
# Cartridge Program Bank and Mirroring Decoder

This block sits on the CPU side of a cartridge mapper. It watches CPU writes to the upper half of the address space and loads three small registers from them: the bank shown in the first switchable 8 KiB program window, the bank shown in the second switchable window, and a 2-bit nametable mirroring mode. Before it decodes registers, it turns CPU address lines A3 and A2 into the chip's register-select lines 1 and 0.

From the register contents, the block translates each CPU address into a program ROM address, or into a select and offset for 8 KiB of work RAM. The two upper program windows are hard-wired to the last two banks of the ROM. The bank count is a parameter and does not have to be a power of two. A stored bank number is reduced modulo that count, so no program address ever points past the end of the ROM.

Register writes take effect at the clock edge where the write strobe is high. Address translation is combinational, using the registered bank values.

Top module: `crt_prg_mapper`

## Requirements
- R1: After reset, the mirroring output is 0 (vertical), and both switchable windows map bank 0.
- R2: The chip register-select value is {A3, A2} of the CPU address. The mirroring register is written only when this value is 0. Address bits A0, A1 and A4–A11 have no effect on register decode, so a write to $9001 loads mirroring, while writes to $9004, $9008 and $900C are ignored.
- R3: A write anywhere in $8000–$8FFF loads data bits 5:0 as the bank for the $8000–$9FFF window. The new bank is visible from the clock edge that samples the write.
- R4: A write anywhere in $A000–$AFFF loads data bits 5:0 as the bank for the $A000–$BFFF window.
- R5: Mirroring takes data bits 1:0. The codes are: 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper.
- R6: Regardless of the register contents, $C000–$DFFF maps bank PRG_BANKS-2 and $E000–$FFFF maps bank PRG_BANKS-1.
- R7: A written bank number is stored modulo PRG_BANKS. For example, with 48 banks, 50 maps bank 2 and 63 maps bank 15.
- R8: The ROM address is {bank, A12..A0}. The ROM select is high only for a read with A15 = 1.
- R9: The work RAM select is high for a read or a write in $6000–$7FFF, and the work RAM address is A12..A0. The ROM and work RAM selects are never high together.
- R10: Register state does not change without a write strobe. It also does not change on a write outside the $8000, $9000 (select 0) and $A000 groups, including writes to $B000–$FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| cpu_rd | input | 1 | Read strobe |
| rom_en | output | 1 | Program ROM select |
| rom_addr | output | BANK_W+13 (19 by default) | Program ROM byte address |
| wram_en | output | 1 | Work RAM select |
| wram_addr | output | 13 | Work RAM byte address |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A register write is due one rising edge after the strobe is driven. The bench therefore raises the strobe on a falling edge and drops it on the next falling edge, and only then issues any read. Address translation and the selects are due in the same cycle as the address. Each read check drives its address on a falling edge and samples 1 ns later, well before the next rising edge. Expected values come from a bench model that is updated at the same point as the write, with the modulo and the select-line rules applied on their own terms.

// File: rtl/crt_prg_pkg.sv
package crt_prg_pkg;
    localparam int FIELD_W = 6;
    localparam int OFFS_W  = 13;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;
endpackage

// File: rtl/crt_prg_regsel.sv
module crt_prg_regsel (
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    output logic        we_bank0,
    output logic        we_bank1,
    output logic        we_mirror
);
    logic [1:0] chip_sel;
    logic [3:0] group;

    always_comb begin
        // CPU A3 drives chip line 1, CPU A2 drives chip line 0
        chip_sel  = {cpu_addr[3], cpu_addr[2]};
        group     = cpu_addr[15:12];
        we_bank0  = cpu_wr && (group == 4'h8);
        we_bank1  = cpu_wr && (group == 4'hA);
        we_mirror = cpu_wr && (group == 4'h9) && (chip_sel == 2'd0);
    end
endmodule

// File: rtl/crt_prg_regs.sv
module crt_prg_regs #(
    parameter int PRG_BANKS = 64,
    parameter int BANK_W    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_bank0,
    input  logic                   we_bank1,
    input  logic                   we_mirror,
    input  logic [7:0]             cpu_wdata,
    output logic [BANK_W-1:0]      bank0,
    output logic [BANK_W-1:0]      bank1,
    output crt_prg_pkg::mirror_e   mirror
);
    import crt_prg_pkg::*;

    typedef struct packed {
        logic [BANK_W-1:0] bank0;
        logic [BANK_W-1:0] bank1;
        mirror_e           mirror;
    } regs_t;

    regs_t       regs_d, regs_q;
    int unsigned reduced;

    always_comb begin
        regs_d  = regs_q;
        reduced = int'(cpu_wdata[FIELD_W-1:0]) % PRG_BANKS;
        if (we_bank0)  regs_d.bank0  = reduced[BANK_W-1:0];
        if (we_bank1)  regs_d.bank1  = reduced[BANK_W-1:0];
        if (we_mirror) regs_d.mirror = mirror_e'(cpu_wdata[1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{bank0: '0, bank1: '0, mirror: MIR_VERT};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bank0  = regs_q.bank0;
    assign bank1  = regs_q.bank1;
    assign mirror = regs_q.mirror;

    // R7: stored bank numbers stay inside the ROM
    p_bank_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(regs_q.bank0) < PRG_BANKS) && (int'(regs_q.bank1) < PRG_BANKS));

    // R10: no write enable, no state change
    p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_bank0 || we_bank1 || we_mirror) |=> $stable(regs_q));
endmodule

// File: rtl/crt_prg_window.sv
module crt_prg_window #(
    parameter int PRG_BANKS = 64,
    parameter int BANK_W    = 6,
    parameter int ROM_AW    = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BANK_W-1:0] bank0,
    input  logic [BANK_W-1:0] bank1,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              wram_en,
    output logic [12:0]       wram_addr
);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(PRG_BANKS - 1);
    localparam logic [BANK_W-1:0] PREV_BANK = BANK_W'(PRG_BANKS - 2);

    logic [BANK_W-1:0] slot_bank;

    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    slot_bank = bank0;
            2'd1:    slot_bank = bank1;
            2'd2:    slot_bank = PREV_BANK;
            default: slot_bank = LAST_BANK;
        endcase
        rom_addr  = {slot_bank, cpu_addr[12:0]};
        rom_en    = cpu_rd && cpu_addr[15];
        wram_en   = (cpu_rd || cpu_wr) && (cpu_addr[15:13] == 3'b011);
        wram_addr = cpu_addr[12:0];
    end

    // R6: the top window never follows a register
    p_top_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (rom_addr[ROM_AW-1:13] == LAST_BANK));

    // R9: ROM and work RAM selects are exclusive
    p_sel_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_en, wram_en}));
endmodule

// File: rtl/crt_prg_mapper.sv
module crt_prg_mapper #(
    parameter int PRG_BANKS = 64,
    parameter int BANK_W    = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    parameter int ROM_AW    = BANK_W + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              wram_en,
    output logic [12:0]       wram_addr,
    output logic [1:0]        mirror_mode
);
    import crt_prg_pkg::*;

    logic              we_bank0, we_bank1, we_mirror;
    logic [BANK_W-1:0] bank0, bank1;
    mirror_e           mirror;

    crt_prg_regsel u_regsel (
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .we_bank0  (we_bank0),
        .we_bank1  (we_bank1),
        .we_mirror (we_mirror)
    );

    crt_prg_regs #(.PRG_BANKS(PRG_BANKS), .BANK_W(BANK_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_bank0  (we_bank0),
        .we_bank1  (we_bank1),
        .we_mirror (we_mirror),
        .cpu_wdata (cpu_wdata),
        .bank0     (bank0),
        .bank1     (bank1),
        .mirror    (mirror)
    );

    crt_prg_window #(.PRG_BANKS(PRG_BANKS), .BANK_W(BANK_W), .ROM_AW(ROM_AW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .bank0     (bank0),
        .bank1     (bank1),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .wram_en   (wram_en),
        .wram_addr (wram_addr)
    );

    assign mirror_mode = mirror;

    // R2, R5: a select-0 write in the $9000 group loads the 2-bit field
    p_mirror_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'h9 && cpu_addr[3:2] == 2'b00)
        |=> (mirror_mode == $past(cpu_wdata[1:0])));

    // R2: other chip selects in the $9000 group leave mirroring alone
    p_mirror_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'h9 && cpu_addr[3:2] != 2'b00)
        |=> $stable(mirror_mode));

    // R10: without a write strobe the mirroring output holds
    p_mirror_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(mirror_mode));
endmodule

// File: tb/crt_prg_mapper_bench.sv
module crt_prg_mapper_bench;
    localparam int NB     = 48;
    localparam int BW     = $clog2(NB);
    localparam int AW     = BW + 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          cpu_wr = 1'b0;
    logic          cpu_rd = 1'b0;
    logic          rom_en, wram_en;
    logic [AW-1:0] rom_addr;
    logic [12:0]   wram_addr;
    logic [1:0]    mirror_mode;

    int total = 0;
    int bad   = 0;
    int m_b0, m_b1, m_mir;

    always #5 clk = ~clk;

    crt_prg_mapper #(.PRG_BANKS(NB)) u_crt_prg_mapper (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_wr (cpu_wr), .cpu_rd (cpu_rd), .rom_en (rom_en), .rom_addr (rom_addr),
        .wram_en (wram_en), .wram_addr (wram_addr), .mirror_mode (mirror_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_bank(input logic [15:0] a);
        case (a[14:13])
            2'd0:    return m_b0;
            2'd1:    return m_b1;
            2'd2:    return NB - 2;
            default: return NB - 1;
        endcase
    endfunction

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
        if (a[15:13] == 3'b011) check("R9 wram_en on write", int'(wram_en), 1);
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[15:12] == 4'h8) m_b0 = int'(d[5:0]) % NB;
        if (a[15:12] == 4'hA) m_b1 = int'(d[5:0]) % NB;
        if (a[15:12] == 4'h9 && a[3:2] == 2'b00) m_mir = int'(d[1:0]);
    endtask

    task automatic cpu_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        check("R8 rom_en", int'(rom_en), int'(a[15]));
        check("R9 wram_en", int'(wram_en), int'(a[15:13] == 3'b011));
        if (a[15]) check("R8/R3/R4/R6 rom_addr", int'(rom_addr), (exp_bank(a) << 13) | int'(a[12:0]));
        if (a[15:13] == 3'b011) check("R9 wram_addr", int'(wram_addr), int'(a[12:0]));
        check("R5/R10 mirror", int'(mirror_mode), m_mir);
        cpu_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h0BAD5EED);
        m_b0 = 0; m_b1 = 0; m_mir = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cpu_read(16'h8123);
        check("R1 bank0 reset", int'(rom_addr[AW-1:13]), 0);
        cpu_read(16'hA000);
        check("R1 bank1 reset", int'(rom_addr[AW-1:13]), 0);
        check("R1 mirror reset", int'(mirror_mode), 0);

        // R3, R4 directed
        cpu_write(16'h8FF3, 8'h05); cpu_read(16'h9ABC);
        cpu_write(16'hA00C, 8'hC7); cpu_read(16'hB001);

        // R7 modulo corners
        cpu_write(16'h8000, 8'd50); cpu_read(16'h8000);
        check("R7 50 mod 48", int'(rom_addr[AW-1:13]), 2);
        cpu_write(16'hA000, 8'd63); cpu_read(16'hA000);
        check("R7 63 mod 48", int'(rom_addr[AW-1:13]), 15);
        cpu_write(16'h8000, 8'd47); cpu_read(16'h8000);
        check("R7 47 kept", int'(rom_addr[AW-1:13]), 47);

        // R2 register select from A3:A2
        cpu_write(16'h9001, 8'h01); cpu_read(16'hE000);
        check("R2 9001 loads", int'(mirror_mode), 1);
        cpu_write(16'h9004, 8'h02); cpu_read(16'hE000);
        check("R2 9004 ignored", int'(mirror_mode), 1);
        cpu_write(16'h9008, 8'h03); cpu_read(16'hE000);
        check("R2 9008 ignored", int'(mirror_mode), 1);
        cpu_write(16'h900C, 8'h00); cpu_read(16'hE000);
        check("R2 900C ignored", int'(mirror_mode), 1);
        cpu_write(16'h9FF3, 8'hFE); cpu_read(16'hE000);
        check("R5 code 2 single lower", int'(mirror_mode), 2);
        cpu_write(16'h9010, 8'h03); cpu_read(16'hE000);
        check("R5 code 3 single upper", int'(mirror_mode), 3);

        // R6, R10: writes above $B000 change nothing
        cpu_write(16'hC000, 8'h11); cpu_write(16'hE000, 8'h22); cpu_write(16'hB000, 8'h05);
        cpu_write(16'h7000, 8'h09);
        cpu_read(16'hC555);
        check("R6 C000 window", int'(rom_addr[AW-1:13]), NB - 2);
        cpu_read(16'hFFFF);
        check("R6 E000 window", int'(rom_addr[AW-1:13]), NB - 1);
        cpu_read(16'h8000); cpu_read(16'hA000);
        cpu_read(16'h6000); cpu_read(16'h7FFF); cpu_read(16'h5FFF);

        // randomized mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = 8'($urandom);
            case ($urandom % 4)
                0: a[15:12] = 4'h8;
                1: begin a[15:12] = 4'h9; if ($urandom % 2 == 0) a[3:2] = 2'b00; end
                2: a[15:12] = 4'hA;
                default: ;
            endcase
            cpu_write(a, d);
            cpu_read(16'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule